// File: doc/BRIEF.md
# Low-Power Exit Command Sequencer

This block sits in a graphics DRAM controller between the command scheduler and the command pins. It decides the clock-enable level for power-down and self-refresh. It chooses each cycle whether the scheduler's command passes through to the device or is replaced by a NOP or DESEL. During an exit it holds the command stream at NOP for a programmable number of cycles and then raises a ready flag, after which normal traffic may resume.

Power-down is entered on request, but not while a refresh is due. It is left on a wake request, or automatically when a refresh falls due, because no refresh can run while the device is powered down. Self-refresh is left only once the clock is reported stable. That exit may use either a loaded wait length or a fixed conservative wait of 1000 cycles. The bank-open state sampled at power-down entry is kept, so that the scheduler knows which commands are legal after the wake. One clock-enable decision is fanned out to every rank sharing the command bus.

Top module: `lpx_seq`

## Requirements
- R1: After reset, every `cke` bit is 1, `cmd_sel` is 0 (pass-through), `ready` is 1 and `refresh_wake` is 0.
- R2: A `pd_req` seen while ready and no refresh is due makes the next cycle drive all `cke` bits to 0, `cmd_sel` to 1 (NOP) and `ready` to 0; `cmd_sel` is never 0 while `cke` is 0.
- R3: A `wake_req` or `refresh_due` in power-down raises `cke` and holds `cmd_sel` at 1 (NOP) with `ready` low for exactly the loaded power-down exit length (a loaded 0 counts as 1), and `ready` returns to 1 in the very next cycle with `cmd_sel` 0.
- R4: After a self-refresh exit starts, `cke` is 1 and `cmd_sel` is 1 (NOP) with `ready` low for exactly the loaded self-refresh exit length (0 counts as 1), or exactly 1000 cycles when the safe-mode bit was loaded as 1.
- R5: In self-refresh, `cmd_sel` is 2 (DESEL) and `cke` stays 0 after `sr_exit_req` until `clk_stable` is seen high; the exit request is remembered, and the wait starts on the edge where `clk_stable` is high.
- R6: A power-down exit caused by `refresh_due` without `wake_req` sets `refresh_wake` to 1; an exit caused by `wake_req` sets it to 0.
- R7: While `refresh_due` is high, a power-down request from the ready state is not taken; it is kept and taken on the first edge after `refresh_due` drops.
- R8: A `pd_req` arriving during an exit wait does not end or shorten the wait; it is held and power-down is entered on the edge after the first ready cycle.
- R9: All bits of `cke` always carry the same value.
- R10: `entry_banks_open` shows the `banks_open` value sampled at the last power-down entry and holds it through the wake.
- R11: Exit lengths and the safe-mode bit are updated only on cycles with `cfg_we` high; the length in use is the one loaded when a wait starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pd_req | input | 1 | Request to enter power-down |
| wake_req | input | 1 | Request to leave power-down |
| sr_req | input | 1 | Request to enter self-refresh (wins over pd_req) |
| sr_exit_req | input | 1 | Request to leave self-refresh |
| clk_stable | input | 1 | Device clock reported stable |
| refresh_due | input | 1 | A refresh is owed to the device |
| banks_open | input | 1 | Some bank is open at this time |
| cfg_we | input | 1 | Load the configuration fields |
| cfg_xp_len | input | CNT_W | Power-down exit wait length |
| cfg_xs_len | input | CNT_W | Self-refresh exit wait length |
| cfg_xs_safe | input | 1 | Use the fixed 1000-cycle self-refresh wait |
| cke | output | NUM_RANKS | Clock enable for each rank |
| cmd_sel | output | 2 | 0 pass-through, 1 force NOP, 2 force DESEL |
| ready | output | 1 | Normal commands may be issued |
| entry_banks_open | output | 1 | Bank-open state captured at power-down entry |
| refresh_wake | output | 1 | Last power-down exit was forced by refresh |

## Verification
The power-down exit is swept over loaded lengths 0 to 7. The bank-open bit and the wake cause vary across the sweep, so the exact count of NOP cycles tells a correct counter from one that is off by one or ignores the zero clamp. The self-refresh exit is swept over lengths 0 to 5 with clock-stable delays of 0 to 2 cycles, which separates a remembered exit request from one that is dropped or acted on early. A single safe-mode exit must last 1000 cycles. Directed cases hold a refresh against a power-down request, pulse a power-down request in mid-wait, and change the configuration inputs without the write enable; each of these shows the difference between a held request or value and one that leaks through.

// File: rtl/lpx_pkg.sv
package lpx_pkg;

   typedef enum logic [1:0] {
      CMD_PASS  = 2'b00,
      CMD_NOP   = 2'b01,
      CMD_DESEL = 2'b10
   } lpx_cmd_e;

   typedef enum logic [2:0] {
      ST_ACTIVE  = 3'd0,
      ST_PD      = 3'd1,
      ST_SR      = 3'd2,
      ST_XP_WAIT = 3'd3,
      ST_XS_WAIT = 3'd4
   } lpx_state_e;

   localparam int unsigned SAFE_XS_CYCLES = 1000;

endpackage

// File: rtl/lpx_cfg_regs.sv
module lpx_cfg_regs #(
   parameter int unsigned CNT_W   = 12,
   parameter int unsigned DEF_XP  = 4,
   parameter int unsigned DEF_XS  = 16,
   parameter int unsigned SAFE_XS = 1000
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [CNT_W-1:0] xp_in,
   input  logic [CNT_W-1:0] xs_in,
   input  logic             safe_in,
   output logic [CNT_W-1:0] xp_eff,
   output logic [CNT_W-1:0] xs_eff
);
   localparam logic [CNT_W-1:0] ONE     = CNT_W'(1);
   localparam logic [CNT_W-1:0] SAFE_V  = CNT_W'(SAFE_XS);

   logic [CNT_W-1:0] xp_q, xs_q;
   logic             safe_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         xp_q   <= CNT_W'(DEF_XP);
         xs_q   <= CNT_W'(DEF_XS);
         safe_q <= 1'b0;
      end else if (we) begin
         xp_q   <= xp_in;
         xs_q   <= xs_in;
         safe_q <= safe_in;
      end
   end

   always_comb begin
      xp_eff = (xp_q == '0) ? ONE : xp_q;
      if (safe_q)
         xs_eff = SAFE_V;
      else
         xs_eff = (xs_q == '0) ? ONE : xs_q;
   end

endmodule

// File: rtl/lpx_exit_timer.sv
module lpx_exit_timer #(
   parameter int unsigned CNT_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [CNT_W-1:0] load_val,
   output logic             done
);
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (start)
         cnt_q <= load_val;
      else if (cnt_q != '0)
         cnt_q <= cnt_q - CNT_W'(1);
   end

   assign done = (cnt_q == CNT_W'(1));

   // R3
   load_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> (cnt_q != '0));

   // R4
   steady_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!start && cnt_q > CNT_W'(1)) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));

endmodule

// File: rtl/lpx_cke_fanout.sv
module lpx_cke_fanout #(
   parameter int unsigned NUM_RANKS = 2
) (
   input  logic                 cke_i,
   output logic [NUM_RANKS-1:0] cke_o
);
   for (genvar r = 0; r < NUM_RANKS; r++) begin : g_rank
      assign cke_o[r] = cke_i;
   end

endmodule

// File: rtl/lpx_seq.sv
module lpx_seq
   import lpx_pkg::*;
#(
   parameter int unsigned CNT_W     = 12,
   parameter int unsigned NUM_RANKS = 2,
   parameter int unsigned DEF_XP    = 4,
   parameter int unsigned DEF_XS    = 16
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 pd_req,
   input  logic                 wake_req,
   input  logic                 sr_req,
   input  logic                 sr_exit_req,
   input  logic                 clk_stable,
   input  logic                 refresh_due,
   input  logic                 banks_open,
   input  logic                 cfg_we,
   input  logic [CNT_W-1:0]     cfg_xp_len,
   input  logic [CNT_W-1:0]     cfg_xs_len,
   input  logic                 cfg_xs_safe,
   output logic [NUM_RANKS-1:0] cke,
   output logic [1:0]           cmd_sel,
   output logic                 ready,
   output logic                 entry_banks_open,
   output logic                 refresh_wake
);
   localparam int unsigned SAFE_BITS = $clog2(SAFE_XS_CYCLES + 1);

   if (CNT_W < SAFE_BITS) begin : g_bad_width
      $error("CNT_W too small for the safe self-refresh wait");
   end
   if (NUM_RANKS < 1) begin : g_bad_ranks
      $error("NUM_RANKS must be at least 1");
   end

   lpx_state_e       state_q, state_d;
   logic             pd_pend_q, pd_pend_d;
   logic             sr_pend_q, sr_pend_d;
   logic             banks_q, rwake_q;
   logic             tmr_start, tmr_done, go_pd, go_xp, go_xs;
   logic [CNT_W-1:0] xp_eff, xs_eff, tmr_load;
   logic             cke_int;

   lpx_cfg_regs #(
      .CNT_W(CNT_W), .DEF_XP(DEF_XP), .DEF_XS(DEF_XS), .SAFE_XS(SAFE_XS_CYCLES)
   ) u_cfg (
      .clk(clk), .rst_n(rst_n), .we(cfg_we),
      .xp_in(cfg_xp_len), .xs_in(cfg_xs_len), .safe_in(cfg_xs_safe),
      .xp_eff(xp_eff), .xs_eff(xs_eff)
   );

   lpx_exit_timer #(.CNT_W(CNT_W)) u_tmr (
      .clk(clk), .rst_n(rst_n), .start(tmr_start), .load_val(tmr_load), .done(tmr_done)
   );

   lpx_cke_fanout #(.NUM_RANKS(NUM_RANKS)) u_fan (
      .cke_i(cke_int), .cke_o(cke)
   );

   always_comb begin
      go_pd = (state_q == ST_ACTIVE) && !sr_req && (pd_req || pd_pend_q) && !refresh_due;
      go_xp = (state_q == ST_PD) && (wake_req || refresh_due);
      go_xs = (state_q == ST_SR) && (sr_exit_req || sr_pend_q) && clk_stable;
      tmr_start = go_xp || go_xs;
      tmr_load  = go_xs ? xs_eff : xp_eff;

      state_d = state_q;
      unique case (state_q)
         ST_ACTIVE:  if (sr_req) state_d = ST_SR;
                     else if (go_pd) state_d = ST_PD;
         ST_PD:      if (go_xp) state_d = ST_XP_WAIT;
         ST_SR:      if (go_xs) state_d = ST_XS_WAIT;
         ST_XP_WAIT: if (tmr_done) state_d = ST_ACTIVE;
         ST_XS_WAIT: if (tmr_done) state_d = ST_ACTIVE;
         default:    state_d = ST_ACTIVE;
      endcase

      if (go_pd || state_q == ST_PD || state_q == ST_SR)
         pd_pend_d = 1'b0;
      else
         pd_pend_d = pd_pend_q || pd_req;

      if (state_q == ST_SR)
         sr_pend_d = (sr_pend_q || sr_exit_req) && !go_xs;
      else
         sr_pend_d = 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= ST_ACTIVE;
         pd_pend_q <= 1'b0;
         sr_pend_q <= 1'b0;
         banks_q   <= 1'b0;
         rwake_q   <= 1'b0;
      end else begin
         state_q   <= state_d;
         pd_pend_q <= pd_pend_d;
         sr_pend_q <= sr_pend_d;
         if (go_pd) banks_q <= banks_open;
         if (go_xp) rwake_q <= refresh_due && !wake_req;
      end
   end

   always_comb begin
      cke_int = !(state_q == ST_PD || state_q == ST_SR);
      unique case (state_q)
         ST_ACTIVE: cmd_sel = CMD_PASS;
         ST_SR:     cmd_sel = CMD_DESEL;
         default:   cmd_sel = CMD_NOP;
      endcase
   end

   assign ready            = (state_q == ST_ACTIVE);
   assign entry_banks_open = banks_q;
   assign refresh_wake     = rwake_q;

   // R2
   entry_with_nop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(cke_int) && !$past(sr_req)) |-> (cmd_sel == CMD_NOP));

   // R2
   no_pass_when_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cke_int |-> (cmd_sel != CMD_PASS));

   // R3
   ready_after_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ready) |-> $past(tmr_done));

   // R5
   sr_clk_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(cke_int) && $past(state_q) == ST_SR) |-> $past(clk_stable));

   // R7
   no_entry_on_refresh_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(cke_int) && !$past(sr_req)) |-> !$past(refresh_due));

   // R8
   hold_in_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pd_req && !tmr_done && (state_q == ST_XP_WAIT || state_q == ST_XS_WAIT)) |=> cke_int);

endmodule

// File: tb/lpx_seq_bench.sv
module lpx_seq_bench;
   localparam int CNT_W = 12;
   localparam int NR    = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic pd_req = 0, wake_req = 0, sr_req = 0, sr_exit_req = 0;
   logic clk_stable = 1, refresh_due = 0, banks_open = 0;
   logic cfg_we = 0, cfg_xs_safe = 0;
   logic [CNT_W-1:0] cfg_xp_len = '0, cfg_xs_len = '0;
   logic [NR-1:0] cke;
   logic [1:0] cmd_sel;
   logic ready, entry_banks_open, refresh_wake;

   int checks = 0;
   int failures = 0;

   always #5 clk = ~clk;

   lpx_seq #(.CNT_W(CNT_W), .NUM_RANKS(NR)) u_lpx_seq (
      .clk(clk), .rst_n(rst_n), .pd_req(pd_req), .wake_req(wake_req),
      .sr_req(sr_req), .sr_exit_req(sr_exit_req), .clk_stable(clk_stable),
      .refresh_due(refresh_due), .banks_open(banks_open), .cfg_we(cfg_we),
      .cfg_xp_len(cfg_xp_len), .cfg_xs_len(cfg_xs_len), .cfg_xs_safe(cfg_xs_safe),
      .cke(cke), .cmd_sel(cmd_sel), .ready(ready),
      .entry_banks_open(entry_banks_open), .refresh_wake(refresh_wake)
   );

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic tick;
      @(negedge clk);
   endtask

   // counts samples with ready low (checking cke high, NOP) until ready
   task automatic measure(input string req, output int n);
      n = 0;
      while (!ready && n < 3000) begin
         chk({req, " wait cke"}, int'(cke), (1 << NR) - 1);
         chk({req, " wait nop"}, int'(cmd_sel), 1);
         n++;
         tick();
      end
   endtask

   task automatic load_cfg(input int xp, input int xs, input bit safe);
      cfg_xp_len = CNT_W'(xp); cfg_xs_len = CNT_W'(xs); cfg_xs_safe = safe;
      cfg_we = 1; tick(); cfg_we = 0;
   endtask

   task automatic pd_round(input int len, input bit banks, input bit by_refresh);
      int n;
      load_cfg(len, 3, 0);
      pd_req = 1; banks_open = banks; tick(); pd_req = 0; banks_open = ~banks;
      chk("R2 entry cke", int'(cke), 0);
      chk("R2 entry nop", int'(cmd_sel), 1);
      chk("R2 entry ready", int'(ready), 0);
      chk("R10 banks captured", int'(entry_banks_open), int'(banks));
      tick();
      chk("R2 stays down", int'(cke), 0);
      if (by_refresh) refresh_due = 1; else wake_req = 1;
      tick(); refresh_due = 0; wake_req = 0;
      measure("R3", n);
      chk("R3 wait length", n, (len == 0) ? 1 : len);
      chk("R3 ready pass", int'(cmd_sel), 0);
      chk("R6 wake cause", int'(refresh_wake), int'(by_refresh));
      chk("R10 banks held", int'(entry_banks_open), int'(banks));
   endtask

   task automatic sr_round(input int len, input bit safe, input int delay);
      int n;
      load_cfg(2, len, safe);
      sr_req = 1; tick(); sr_req = 0;
      chk("R5 sr cke", int'(cke), 0);
      chk("R5 sr desel", int'(cmd_sel), 2);
      clk_stable = (delay == 0);
      sr_exit_req = 1; tick(); sr_exit_req = 0;
      for (int d = 0; d < delay; d++) begin
         chk("R5 held low until stable", int'(cke), 0);
         if (d == delay - 1) clk_stable = 1;
         tick();
      end
      measure("R4", n);
      chk("R4 wait length", n, safe ? 1000 : ((len == 0) ? 1 : len));
   endtask

   initial begin
      int n;
      tick(); tick();
      rst_n = 1;
      tick();
      chk("R1 cke", int'(cke), (1 << NR) - 1);
      chk("R1 cmd", int'(cmd_sel), 0);
      chk("R1 ready", int'(ready), 1);
      chk("R1 rwake", int'(refresh_wake), 0);

      for (int l = 0; l < 8; l++) pd_round(l, l[0], l[1]);
      for (int l = 0; l < 6; l++) sr_round(l, 0, l % 3);
      sr_round(5, 1, 1);

      // R7: refresh blocks entry, request retained
      refresh_due = 1; pd_req = 1; tick(); pd_req = 0;
      for (int k = 0; k < 3; k++) begin
         chk("R7 no entry while refresh due", int'(cke), (1 << NR) - 1);
         tick();
      end
      refresh_due = 0; tick();
      chk("R7 entry after refresh drops", int'(cke), 0);
      wake_req = 1; tick(); wake_req = 0;
      measure("R7", n);

      // R8: request during wait is held
      load_cfg(4, 3, 0);
      pd_req = 1; tick(); pd_req = 0;
      wake_req = 1; tick(); wake_req = 0;
      chk("R8 wait started", int'(cke), (1 << NR) - 1);
      tick();
      pd_req = 1; tick(); pd_req = 0;
      n = 2;
      while (!ready && n < 100) begin
         chk("R8 cke high during wait", int'(cke), (1 << NR) - 1);
         n++; tick();
      end
      chk("R8 wait not shortened", n, 4);
      tick();
      chk("R8 held entry taken", int'(cke), 0);

      // R11: inputs without write enable are ignored
      cfg_xp_len = CNT_W'(9);
      wake_req = 1; tick(); wake_req = 0;
      measure("R11", n);
      chk("R11 old length kept", n, 4);
      chk("R9 ranks equal", int'(cke[0] == cke[1]), 1);

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   // R9: ranks always agree
   always @(negedge clk) if (rst_n && cke[0] != cke[1]) chk("R9 ranks differ", int'(cke), 0);

endmodule